// File: doc/BRIEF.md
# Stacked Inset Window Overlay Generator

This block decides, for every pixel of the main raster, whether an inset window covers it and what that pixel shows. It takes the main pixel and line counters along with a set of control fields: window size, horizontal and vertical placement, per-window enable and blank bits, live-window select, border colour code, fill code, and a free-run flat-field control. From these it produces the video switch control, the index of the covering window, a border flag, a source code, and a 24-bit RGB colour for pixels whose content is a generated colour.

There can be three or four equal windows, stacked one directly under the next. Exactly one of them carries live inset video, and the rest show stored pictures. Each window is surrounded by a ring of border pixels. The placement fields are clamped so that the whole stack stays clear of the horizontal and vertical sync intervals at the start of each line and field. Every output is registered, so each one appears one clock after the counter values that produced it.

Top module: `pip_ovl_top`

## Requirements
- R1: `size_i`=0 selects four windows, each with an 84-pel by 53-line picture area. `size_i`=1 selects three windows, each with a 114-pel by 71-line picture area. Window index 3 is never reported in the three-window mode.
- R2: Each window region adds a border ring 3 pels wide on the left and right and 2 lines tall on the top and bottom. The region is 6 pels wider and 4 lines taller than the picture area. Window k starts k region-heights below the top of the stack.
- R3: The stack's left edge is X = min(80 + 12·`xpos_i`, 910 − region width). Its top line is Y = min(20 + 3·`ypos_i`, 262 − window count × region height). The defaults assume 910 pels per line and 262 lines per field.
- R4: `live_sel_i` marks one window as live, with window 0 at the top. In the picture area, the live window reports source 1 and every other shown window reports source 2. Code 11 selects window 3 in four-window mode and window 2 in three-window mode.
- R5: Border codes map to colours as follows: 000 black 000000, 001 70% white B3B3B3, 100 blue 0000FF, 101 green 00FF00, 110 red FF0000, 111 white FFFFFF. Each of these sets `border_o`=1 and source 3. Codes 010 and 011 are transparent: the ring shows the main picture with insert 0.
- R6: `win_en_i` bit k enables window k. A disabled window, or one that does not exist in the current mode, shows the main picture.
- R7: `win_blank_i` bit k turns window k's picture area to black (source 3, 000000) and leaves its border unchanged. A blank bit set while the window is disabled takes effect as soon as the window is enabled.
- R8: In every enabled picture area, fill code 01 gives red FF0000, 10 gives green 00FF00, and 11 gives blue 0000FF, all as source 3. Fill code 00 leaves the window content unchanged.
- R9: While `free_run_i`=1, every pixel is source 3 with index 0 and border 0. The colour is dark blue 000080 when `bg_white_i`=0 and grey 808080 when it is 1.
- R10: Priority from highest to lowest is free-run, border, fill, blank, window video, main. Source 0 means main picture, with insert 0, index 0 and colour 000000. `insert_o` is 1 for every other source.
- R11: Outputs are registered with one clock of latency. While `rst_ni` is low, all outputs are 0.
- R12: Outside free-run, no pixel with pixel count below 80 or line count below 20 is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_cnt_i | input | 10 | Main pixel counter |
| v_cnt_i | input | 9 | Main line counter |
| size_i | input | 1 | 0: four small windows, 1: three large windows |
| xpos_i | input | 6 | Horizontal placement step |
| ypos_i | input | 6 | Vertical placement step |
| win_en_i | input | 4 | Per-window enable, bit 0 is the top window |
| win_blank_i | input | 4 | Per-window blank to black |
| live_sel_i | input | 2 | Live window select |
| border_code_i | input | 3 | Border palette code |
| fill_code_i | input | 2 | Solid fill code |
| free_run_i | input | 1 | Flat field over the whole raster |
| bg_white_i | input | 1 | Flat field colour select |
| insert_o | output | 1 | Video switch: 1 selects the inset path |
| src_o | output | 2 | 0 main, 1 live, 2 stored, 3 generated colour |
| win_idx_o | output | 2 | Index of the window shown |
| border_o | output | 1 | Opaque border pixel |
| colour_o | output | 24 | RGB override, red in the top byte |

## Verification
On every cycle, the assertions check several properties. The border flag always comes with a generated colour, and free-run forces a flat field. No enabled window means no insert. The sync keep-out holds on both axes, and three-window mode never reports index 3. Other behaviour depends on exact geometry, and only the directed scenarios can show it. This covers the pixel-exact window, border and clamp edges, the live-select mapping in each mode, the full border palette with its transparent codes, and the fill and blank ordering. It also includes the deferred effect of a blank bit set before its window is enabled.

// File: rtl/pip_ovl_pkg.sv
package pip_ovl_pkg;
  localparam int N_WIN_MAX = 4;
  localparam int IDX_W     = 2;

  typedef enum logic [1:0] {
    SRC_MAIN   = 2'd0,
    SRC_LIVE   = 2'd1,
    SRC_STORED = 2'd2,
    SRC_COLOUR = 2'd3
  } src_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic logic border_opaque(logic [2:0] code);
    return code[2:1] != 2'b01;
  endfunction

  function automatic rgb_t border_rgb(logic [2:0] code);
    rgb_t c;
    case (code)
      3'b001:  c = '{8'hB3, 8'hB3, 8'hB3};
      3'b100:  c = '{8'h00, 8'h00, 8'hFF};
      3'b101:  c = '{8'h00, 8'hFF, 8'h00};
      3'b110:  c = '{8'hFF, 8'h00, 8'h00};
      3'b111:  c = '{8'hFF, 8'hFF, 8'hFF};
      default: c = '{8'h00, 8'h00, 8'h00};
    endcase
    return c;
  endfunction

  function automatic rgb_t fill_rgb(logic [1:0] code);
    rgb_t c;
    case (code)
      2'b01:   c = '{8'hFF, 8'h00, 8'h00};
      2'b10:   c = '{8'h00, 8'hFF, 8'h00};
      2'b11:   c = '{8'h00, 8'h00, 8'hFF};
      default: c = '{8'h00, 8'h00, 8'h00};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pip_ovl_place.sv
module pip_ovl_place #(
  parameter int H_PIX    = 910,
  parameter int V_LINES  = 262,
  parameter int H_SYNC   = 80,
  parameter int V_SYNC   = 20,
  parameter int POS_W    = 6,
  parameter int W_BIG    = 114,
  parameter int H_BIG    = 71,
  parameter int N_BIG    = 3,
  parameter int W_SMALL  = 84,
  parameter int H_SMALL  = 53,
  parameter int N_SMALL  = 4,
  parameter int BORDER_H = 3,
  parameter int BORDER_V = 2,
  parameter int HW       = 10,
  parameter int VW       = 9
) (
  input  logic             size_i,
  input  logic [POS_W-1:0] xpos_i,
  input  logic [POS_W-1:0] ypos_i,
  output logic [HW-1:0]    x0_o,
  output logic [VW-1:0]    y0_o,
  output logic [HW-1:0]    win_w_o,
  output logic [VW-1:0]    win_h_o,
  output logic [2:0]       n_win_o
);
  localparam int H_STEP = (H_PIX - H_SYNC) / (1 << POS_W);
  localparam int V_STEP = (V_LINES - V_SYNC) / (1 << POS_W);

  int w, h, n, xr, yr, xmax, ymax, x0, y0;

  always_comb begin
    w    = size_i ? W_BIG : W_SMALL;
    h    = size_i ? H_BIG : H_SMALL;
    n    = size_i ? N_BIG : N_SMALL;
    xr   = H_SYNC + int'(xpos_i) * H_STEP;
    yr   = V_SYNC + int'(ypos_i) * V_STEP;
    // keep the whole stack inside the visible raster
    xmax = H_PIX - (w + 2 * BORDER_H);
    ymax = V_LINES - n * (h + 2 * BORDER_V);
    x0   = (xr > xmax) ? xmax : xr;
    y0   = (yr > ymax) ? ymax : yr;
  end

  assign x0_o    = HW'(x0);
  assign y0_o    = VW'(y0);
  assign win_w_o = HW'(w);
  assign win_h_o = VW'(h);
  assign n_win_o = 3'(n);
endmodule

// File: rtl/pip_ovl_locate.sv
module pip_ovl_locate
  import pip_ovl_pkg::*;
#(
  parameter int BORDER_H = 3,
  parameter int BORDER_V = 2,
  parameter int HW       = 10,
  parameter int VW       = 9
) (
  input  logic [HW-1:0]    h_i,
  input  logic [VW-1:0]    v_i,
  input  logic [HW-1:0]    x0_i,
  input  logic [VW-1:0]    y0_i,
  input  logic [HW-1:0]    win_w_i,
  input  logic [VW-1:0]    win_h_i,
  input  logic [2:0]       n_win_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ring_o
);
  int slot, reg_w, dx, dy, rowoff;
  logic [N_WIN_MAX-1:0] row_hit;

  always_comb begin
    slot  = int'(win_h_i) + 2 * BORDER_V;
    reg_w = int'(win_w_i) + 2 * BORDER_H;
    dx    = int'(h_i) - int'(x0_i);
    dy    = int'(v_i) - int'(y0_i);
  end

  for (genvar k = 0; k < N_WIN_MAX; k++) begin : g_row
    assign row_hit[k] = (k < int'(n_win_i)) && (dy >= k * slot) && (dy < (k + 1) * slot);
  end

  always_comb begin
    idx_o  = '0;
    rowoff = 0;
    for (int k = 0; k < N_WIN_MAX; k++) begin
      if (row_hit[k]) begin
        idx_o  = IDX_W'(k);
        rowoff = dy - k * slot;
      end
    end
  end

  assign hit_o  = (dx >= 0) && (dx < reg_w) && (|row_hit);
  assign ring_o = (rowoff < BORDER_V) || (rowoff >= slot - BORDER_V) ||
                  (dx < BORDER_H) || (dx >= reg_w - BORDER_H);
endmodule

// File: rtl/pip_ovl_mux.sv
module pip_ovl_mux
  import pip_ovl_pkg::*;
(
  input  logic                 hit_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 ring_i,
  input  logic                 size_i,
  input  logic [N_WIN_MAX-1:0] win_en_i,
  input  logic [N_WIN_MAX-1:0] win_blank_i,
  input  logic [IDX_W-1:0]     live_sel_i,
  input  logic [2:0]           border_code_i,
  input  logic [1:0]           fill_code_i,
  input  logic                 free_run_i,
  input  logic                 bg_white_i,
  output src_e                 src_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 border_o,
  output rgb_t                 rgb_o
);
  logic             shown;
  logic [IDX_W-1:0] live;

  assign shown = hit_i && win_en_i[idx_i];
  // large mode has no fourth window: top code folds onto the third
  assign live  = (size_i && live_sel_i == 2'b11) ? 2'b10 : live_sel_i;

  always_comb begin
    src_o    = SRC_MAIN;
    idx_o    = '0;
    border_o = 1'b0;
    rgb_o    = '0;
    if (free_run_i) begin
      src_o = SRC_COLOUR;
      rgb_o = bg_white_i ? '{8'h80, 8'h80, 8'h80} : '{8'h00, 8'h00, 8'h80};
    end else if (shown && ring_i) begin
      if (border_opaque(border_code_i)) begin
        src_o    = SRC_COLOUR;
        idx_o    = idx_i;
        border_o = 1'b1;
        rgb_o    = border_rgb(border_code_i);
      end
    end else if (shown) begin
      idx_o = idx_i;
      if (fill_code_i != 2'b00) begin
        src_o = SRC_COLOUR;
        rgb_o = fill_rgb(fill_code_i);
      end else if (win_blank_i[idx_i]) begin
        src_o = SRC_COLOUR;
      end else begin
        src_o = (idx_i == live) ? SRC_LIVE : SRC_STORED;
      end
    end
  end
endmodule

// File: rtl/pip_ovl_top.sv
module pip_ovl_top
  import pip_ovl_pkg::*;
#(
  parameter int H_PIX   = 910,
  parameter int V_LINES = 262,
  parameter int H_SYNC  = 80,
  parameter int V_SYNC  = 20,
  parameter int POS_W   = 6,
  localparam int HW     = $clog2(H_PIX),
  localparam int VW     = $clog2(V_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HW-1:0]        h_cnt_i,
  input  logic [VW-1:0]        v_cnt_i,
  input  logic                 size_i,
  input  logic [POS_W-1:0]     xpos_i,
  input  logic [POS_W-1:0]     ypos_i,
  input  logic [N_WIN_MAX-1:0] win_en_i,
  input  logic [N_WIN_MAX-1:0] win_blank_i,
  input  logic [IDX_W-1:0]     live_sel_i,
  input  logic [2:0]           border_code_i,
  input  logic [1:0]           fill_code_i,
  input  logic                 free_run_i,
  input  logic                 bg_white_i,
  output logic                 insert_o,
  output logic [1:0]           src_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 border_o,
  output logic [23:0]          colour_o
);
  logic [HW-1:0]    x0, win_w;
  logic [VW-1:0]    y0, win_h;
  logic [2:0]       n_win;
  logic             hit, ring, bord_d, bord_q;
  logic [IDX_W-1:0] idx_l, idx_d, idx_q;
  src_e             src_d, src_q;
  rgb_t             rgb_d, rgb_q;

  pip_ovl_place #(
    .H_PIX(H_PIX), .V_LINES(V_LINES), .H_SYNC(H_SYNC), .V_SYNC(V_SYNC),
    .POS_W(POS_W), .HW(HW), .VW(VW)
  ) u_place (
    .size_i(size_i), .xpos_i(xpos_i), .ypos_i(ypos_i),
    .x0_o(x0), .y0_o(y0), .win_w_o(win_w), .win_h_o(win_h), .n_win_o(n_win)
  );

  pip_ovl_locate #(.HW(HW), .VW(VW)) u_locate (
    .h_i(h_cnt_i), .v_i(v_cnt_i), .x0_i(x0), .y0_i(y0),
    .win_w_i(win_w), .win_h_i(win_h), .n_win_i(n_win),
    .hit_o(hit), .idx_o(idx_l), .ring_o(ring)
  );

  pip_ovl_mux u_mux (
    .hit_i(hit), .idx_i(idx_l), .ring_i(ring), .size_i(size_i),
    .win_en_i(win_en_i), .win_blank_i(win_blank_i), .live_sel_i(live_sel_i),
    .border_code_i(border_code_i), .fill_code_i(fill_code_i),
    .free_run_i(free_run_i), .bg_white_i(bg_white_i),
    .src_o(src_d), .idx_o(idx_d), .border_o(bord_d), .rgb_o(rgb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_MAIN;
      idx_q  <= '0;
      bord_q <= 1'b0;
      rgb_q  <= '0;
    end else begin
      src_q  <= src_d;
      idx_q  <= idx_d;
      bord_q <= bord_d;
      rgb_q  <= rgb_d;
    end
  end

  assign insert_o  = (src_q != SRC_MAIN);
  assign src_o     = src_q;
  assign win_idx_o = idx_q;
  assign border_o  = bord_q;
  assign colour_o  = rgb_q;
endmodule

// File: rtl/pip_ovl_chk.sv
module pip_ovl_chk #(
  parameter int H_SYNC = 80,
  parameter int V_SYNC = 20,
  parameter int HW     = 10,
  parameter int VW     = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [HW-1:0] h_cnt_i,
  input logic [VW-1:0] v_cnt_i,
  input logic          size_i,
  input logic [3:0]    win_en_i,
  input logic          free_run_i,
  input logic          insert_o,
  input logic [1:0]    src_o,
  input logic [1:0]    win_idx_o,
  input logic          border_o
);
  p_border_colour_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    border_o |-> (insert_o && src_o == 2'd3));

  p_flat_field_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i |=> (src_o == 2'd3 && !border_o && win_idx_o == 2'd0));

  p_all_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && win_en_i == 4'd0) |=> !insert_o);

  p_hsync_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && h_cnt_i < HW'(H_SYNC)) |=> !insert_o);

  p_vsync_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && v_cnt_i < VW'(V_SYNC)) |=> !insert_o);

  p_three_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i && !free_run_i) |=> win_idx_o != 2'd3);
endmodule

bind pip_ovl_top pip_ovl_chk #(.H_SYNC(H_SYNC), .V_SYNC(V_SYNC), .HW(HW), .VW(VW)) u_chk (.*);

// File: tb/pip_ovl_top_tb_top.sv
`timescale 1ns/1ps
module pip_ovl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] h_cnt = '0;
  logic [8:0] v_cnt = '0;
  logic       size = 1'b0;
  logic [5:0] xpos = '0, ypos = '0;
  logic [3:0] win_en = '0, win_blank = '0;
  logic [1:0] live_sel = '0, fill_code = '0;
  logic [2:0] border_code = '0;
  logic       free_run = 1'b0, bg_white = 1'b0;
  logic       insert, border;
  logic [1:0] src, win_idx;
  logic [23:0] colour;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pip_ovl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .h_cnt_i(h_cnt), .v_cnt_i(v_cnt),
    .size_i(size), .xpos_i(xpos), .ypos_i(ypos), .win_en_i(win_en),
    .win_blank_i(win_blank), .live_sel_i(live_sel), .border_code_i(border_code),
    .fill_code_i(fill_code), .free_run_i(free_run), .bg_white_i(bg_white),
    .insert_o(insert), .src_o(src), .win_idx_o(win_idx), .border_o(border),
    .colour_o(colour)
  );

  function automatic int pw(bit sz); return sz ? 114 : 84; endfunction
  function automatic int ph(bit sz); return sz ? 71 : 53; endfunction
  function automatic int slot(bit sz); return ph(sz) + 4; endfunction
  function automatic int sx0(bit sz, int xp);
    int r = 80 + 12 * xp, m = 910 - (pw(sz) + 6);
    return r > m ? m : r;
  endfunction
  function automatic int sy0(bit sz, int yp);
    int r = 20 + 3 * yp, m = 262 - (sz ? 3 : 4) * slot(sz);
    return r > m ? m : r;
  endfunction
  function automatic logic [23:0] bpal(int c);
    case (c)
      1: return 24'hB3B3B3; 4: return 24'h0000FF; 5: return 24'h00FF00;
      6: return 24'hFF0000; 7: return 24'hFFFFFF; default: return 24'h000000;
    endcase
  endfunction

  task automatic probe(input int h, input int v, input int e_src, input int e_idx,
                       input bit e_bord, input logic [23:0] e_rgb, input string tag);
    bit e_ins = (e_src != 0);
    @(negedge clk);
    h_cnt = h[9:0];
    v_cnt = v[8:0];
    @(posedge clk);
    #1;
    checks++;
    if (insert !== e_ins || src !== e_src[1:0] || win_idx !== e_idx[1:0] ||
        border !== e_bord || colour !== e_rgb) begin
      errors++;
      $display("FAIL %s @(%0d,%0d): ins=%0b src=%0d idx=%0d bord=%0b rgb=%06h expected ins=%0b src=%0d idx=%0d bord=%0b rgb=%06h",
               tag, h, v, insert, src, win_idx, border, colour,
               e_ins, e_src, e_idx, e_bord, e_rgb);
    end
  endtask

  task automatic setup(input bit sz, input int xp, input int yp, input logic [3:0] en);
    @(negedge clk);
    size = sz; xpos = xp[5:0]; ypos = yp[5:0]; win_en = en;
    win_blank = '0; live_sel = '0; fill_code = '0; border_code = 3'b110;
    free_run = 1'b0; bg_white = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    free_run = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (insert !== 1'b0 || src !== 2'd0 || colour !== 24'd0 || border !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: ins=%0b src=%0d rgb=%06h expected 0 0 000000", insert, src, colour);
    end
    @(negedge clk);
    free_run = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_single_small;
    int x, y;
    setup(0, 10, 10, 4'b0001);
    x = sx0(0, 10); y = sy0(0, 10);
    probe(x, y, 3, 0, 1, 24'hFF0000, "R2 top-left border");
    probe(x + 2, y + 10, 3, 0, 1, 24'hFF0000, "R2 left ring");
    probe(x + 3, y + 2, 1, 0, 0, 0, "R4 first picture pel");
    probe(x + 86, y + 54, 1, 0, 0, 0, "R1 last picture pel");
    probe(x + 87, y + 10, 3, 0, 1, 24'hFF0000, "R1 width edge");
    probe(x + 89, y + 10, 3, 0, 1, 24'hFF0000, "R2 right ring");
    probe(x + 90, y + 10, 0, 0, 0, 0, "R2 past region");
    probe(x + 10, y + 57 + 10, 0, 0, 0, 0, "R6 disabled window 1");
  endtask

  task automatic t_large_stack;
    int x, y;
    setup(1, 0, 0, 4'b1111);
    live_sel = 2'b11;
    x = sx0(1, 0); y = sy0(1, 0);
    probe(x + 20, y + 150 + 10, 1, 2, 0, 0, "R4 code 11 maps to third in large");
    probe(x + 20, y + 20, 2, 0, 0, 0, "R4 stored window 0");
    probe(x + 20, y + 72, 2, 0, 0, 0, "R1 last picture line");
    probe(x + 20, y + 73, 3, 0, 1, 24'hFF0000, "R2 bottom ring");
    probe(x + 20, y + 75, 3, 1, 1, 24'hFF0000, "R2 next window top ring");
    probe(x + 20, y + 225 + 5, 0, 0, 0, 0, "R1 no fourth window");
    probe(x + 116, y + 20, 2, 0, 0, 0, "R1 large width");
  endtask

  task automatic t_live_small;
    int x, y;
    setup(0, 0, 0, 4'b1111);
    live_sel = 2'b11;
    x = sx0(0, 0); y = sy0(0, 0);
    probe(x + 20, y + 171 + 10, 1, 3, 0, 0, "R4 code 11 fourth in small");
    @(negedge clk);
    live_sel = 2'b01;
    probe(x + 20, y + 57 + 10, 1, 1, 0, 0, "R4 code 01 second");
    probe(x + 20, y + 171 + 10, 2, 3, 0, 0, "R4 fourth now stored");
  endtask

  task automatic t_palette;
    int x, y;
    setup(0, 20, 5, 4'b0001);
    x = sx0(0, 20); y = sy0(0, 5);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      border_code = c[2:0];
      if (c == 2 || c == 3) probe(x, y + 10, 0, 0, 0, 0, "R5 transparent code");
      else probe(x, y + 10, 3, 0, 1, bpal(c), "R5 palette colour");
    end
  endtask

  task automatic t_fill_blank;
    int x, y;
    setup(0, 5, 0, 4'b0010);
    x = sx0(0, 5); y = sy0(0, 0);
    win_blank = 4'b0010;
    probe(x + 10, y + 57 + 10, 3, 1, 0, 24'h000000, "R7 blanked picture");
    probe(x, y + 57 + 10, 3, 1, 1, 24'hFF0000, "R7 border kept on blank");
    @(negedge clk);
    fill_code = 2'b10;
    probe(x + 10, y + 57 + 10, 3, 1, 0, 24'h00FF00, "R10 fill beats blank");
    @(negedge clk);
    fill_code = 2'b01;
    probe(x + 10, y + 57 + 10, 3, 1, 0, 24'hFF0000, "R8 red fill");
    @(negedge clk);
    fill_code = 2'b11; border_code = 3'b101;
    probe(x + 10, y + 57 + 10, 3, 1, 0, 24'h0000FF, "R8 blue fill");
    probe(x + 1, y + 57 + 10, 3, 1, 1, 24'h00FF00, "R10 border beats fill");
    @(negedge clk);
    fill_code = 2'b00; win_en = 4'b0000; win_blank = 4'b0100;
    probe(x + 10, y + 114 + 10, 0, 0, 0, 0, "R7 blank while off");
    @(negedge clk);
    win_en = 4'b0100;
    probe(x + 10, y + 114 + 10, 3, 2, 0, 24'h000000, "R7 comes up black");
  endtask

  task automatic t_free_run;
    setup(0, 0, 0, 4'b1111);
    free_run = 1'b1;
    probe(5, 5, 3, 0, 0, 24'h000080, "R9 dark blue in sync");
    probe(sx0(0, 0), sy0(0, 0), 3, 0, 0, 24'h000080, "R9 over border");
    @(negedge clk);
    bg_white = 1'b1;
    probe(400, 150, 3, 0, 0, 24'h808080, "R9 grey field");
  endtask

  task automatic t_clamp;
    setup(1, 63, 63, 4'b0001);
    probe(790, 37, 3, 0, 1, 24'hFF0000, "R3 clamp large corner");
    probe(789, 40, 0, 0, 0, 0, "R3 left of clamp");
    probe(909, 40, 3, 0, 1, 24'hFF0000, "R3 last pel of line");
    @(negedge clk);
    size = 1'b0; win_en = 4'b1000;
    probe(820, 34 + 171, 3, 3, 1, 24'hFF0000, "R3 clamp small");
    probe(819, 34 + 171, 0, 0, 0, 0, "R3 left of small clamp");
    probe(820, 261, 3, 3, 1, 24'hFF0000, "R3 last line");
  endtask

  task automatic t_sync_keepout;
    setup(0, 0, 0, 4'b0001);
    probe(79, 30, 0, 0, 0, 0, "R12 before h limit");
    probe(80, 30, 3, 0, 1, 24'hFF0000, "R12 first allowed pel");
    probe(100, 19, 0, 0, 0, 0, "R12 before v limit");
    probe(100, 20, 3, 0, 1, 24'hFF0000, "R12 first allowed line");
    @(negedge clk);
    win_en = 4'b0000;
    probe(100, 40, 0, 0, 0, 0, "R6 all disabled");
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single_small();
    t_large_stack();
    t_live_small();
    t_palette();
    t_fill_blank();
    t_free_run();
    t_clamp();
    t_sync_keepout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule